// File: doc/BRIEF.md
# Time Slot Interchange Switch Core

This core moves bytes between time slots on eight serial lines. Each receive line carries frames of 32 channels. Each channel is one 8-bit byte, sent most significant bit first, and every bit lasts two clock cycles. Every byte that completes is stored in a data memory that is banked by frame parity: the bank being filled during frame N is the one read during frame N+1. For each of the 256 output slots, a connection memory gives the stored byte to send. A source address of 8 bits names any input stream and channel, so any input slot can reach any output slot, with a latency of one frame.

The connection memory also holds two flags per slot. The first is a drive flag, which lets that output slot go to high impedance. The second is a control-channel flag. The control-channel flags are sent out as a separate serial line of 256 bits per frame. A global drive input overrides every per-slot drive flag. An active-low frame pulse realigns the counters. A processor reaches the connection memory through a plain write/read port and reads the data memory through a read port.

Top module: `tsx_switch_core`

## Requirements
- R1: While `rst_n` is low, every `tx_oe` bit is 0. After a reset, all connection-memory entries read back as zero, so `cc_out` is 0. The counters start at channel 0, first bit, with bank 0 as the write bank.
- R2: A bit lasts 2 clock cycles. The receive input is sampled on the second rising edge of the bit. The transmit outputs change only at that edge.
- R3: If `fp_n` is low when it is sampled at the end of a bit, the next bit is the first bit of channel 0 of a new frame. The write and read banks swap at that point. This also applies when the pulse arrives in the middle of a frame.
- R4: With no frame pulse, a frame is 32 channels of 8 bits, and the counters wrap by themselves after 256 bits. The banks swap at the same point.
- R5: Serial bytes are sent and received most significant bit first. Bit position p, where p = 0 is the first bit, carries byte bit 7-p.
- R6: Slot address = stream*32 + channel, so bits [7:5] give the stream and bits [4:0] give the channel. The source word stored for output slot (s,c) uses this same encoding. During frame F, `tx_out[s]` in channel c carries the byte received in frame F-1 at that source.
- R7: A byte is written to the write bank only when all 8 of its bits have arrived. If a frame pulse cuts a channel short, that channel's previous contents stay in the bank. `dm_rd_addr` = {bank, slot address}.
- R8: Output channel 0 of a frame may take its source from the channel that completes on the same edge that ends the previous frame. In that case it carries the newly completed byte.
- R9: `tx_oe[s]` is high during channel c exactly when `ode` is high and the drive flag of slot (s,c) is set.
- R10: When `ode` is low, every `tx_oe` bit is low.
- R11: During bit position p of channel c, `cc_out` equals the control-channel flag of the slot with stream field p and channel c.
- R12: A connection-memory write takes effect on the clock edge where `cm_wr_en` is high. The read ports return the stored values combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, two cycles per bit |
| rst_n | input | 1 | Active-low reset |
| fp_n | input | 1 | Active-low frame pulse, sampled at bit end |
| ode | input | 1 | Global transmit drive enable |
| rx_in | input | 8 | Serial receive streams |
| tx_out | output | 8 | Serial transmit data |
| tx_oe | output | 8 | Per-stream drive enable (low = high impedance) |
| cc_out | output | 1 | Control-channel serial line |
| cm_wr_en | input | 1 | Connection-memory write strobe |
| cm_wr_addr | input | 8 | Slot address to write |
| cm_wr_src | input | 8 | Source slot address for the written slot |
| cm_wr_oe | input | 1 | Drive flag for the written slot |
| cm_wr_cc | input | 1 | Control-channel flag for the written slot |
| cm_rd_addr | input | 8 | Slot address to read |
| cm_rd_src | output | 8 | Stored source address |
| cm_rd_oe | output | 1 | Stored drive flag |
| cm_rd_cc | output | 1 | Stored control-channel flag |
| dm_rd_addr | input | 9 | Data-memory read address {bank, slot} |
| dm_rd_data | output | 8 | Data-memory byte |

## Verification
Two things can happen on the same edge: a receive byte is written, and the first output byte of the next frame is loaded from that same bank. The bench provokes this in two ways. It routes every channel-0 output slot to channel 31 or channel 12 sources. It also sends a frame pulse at the last bit of channel 12, so the truncated frame ends with a write. The bench then compares channel 0 of the next frame against the byte that was completed on that edge. A pulse in the middle of a channel checks the opposite case, where no write happens: the cut-off channel keeps the contents it had two frames earlier, and this is seen both in the switched output and through the data-memory read port.

// File: rtl/tsx_pkg.sv
package tsx_pkg;

  typedef struct packed {
    logic oe;
    logic cc;
  } cm_hi_t;

  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  function automatic int unsigned slot_of(input int unsigned strm, input int unsigned chan,
                                          input int unsigned nch);
    return strm * nch + chan;
  endfunction

endpackage

// File: rtl/tsx_timing.sv
module tsx_timing #(
  parameter int CPB = 2,
  parameter int NCH = 32,
  parameter int W   = 8,
  localparam int PW = (CPB > 1) ? $clog2(CPB) : 1,
  localparam int CW = $clog2(NCH),
  localparam int BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp_n,
  output logic          tick,
  output logic          last_bit,
  output logic          frame_start,
  output logic [CW-1:0] chan,
  output logic [CW-1:0] chan_next,
  output logic [BW-1:0] bpos,
  output logic          wbank
);

  logic [PW-1:0] phase_q;
  logic [BW-1:0] bpos_q;
  logic [CW-1:0] chan_q;
  logic          bank_q;

  assign tick        = (int'(phase_q) == CPB - 1);
  assign last_bit    = (int'(bpos_q) == W - 1);
  assign frame_start = tick && (!fp_n || (last_bit && int'(chan_q) == NCH - 1));
  assign chan_next   = frame_start ? '0 : CW'(tsx_pkg::wrap_inc(32'(chan_q), NCH));
  assign chan        = chan_q;
  assign bpos        = bpos_q;
  assign wbank       = bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      bpos_q  <= '0;
      chan_q  <= '0;
      bank_q  <= 1'b0;
    end else begin
      phase_q <= tick ? '0 : phase_q + 1'b1;
      if (tick) begin
        if (frame_start) begin
          bpos_q <= '0;
          chan_q <= '0;
          bank_q <= ~bank_q;
        end else if (last_bit) begin
          bpos_q <= '0;
          chan_q <= chan_next;
        end else begin
          bpos_q <= bpos_q + 1'b1;
        end
      end
    end
  end

  a_r3_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (chan_q == '0 && bpos_q == '0 && bank_q != $past(bank_q)));

  a_r4_chan_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && last_bit && !frame_start) |=> (chan_q == $past(chan_q) + 1'b1 && bpos_q == '0));

  a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(bpos_q) && $stable(chan_q) && $stable(bank_q)));

endmodule

// File: rtl/tsx_rx_store.sv
module tsx_rx_store #(
  parameter int NSTR = 8,
  parameter int NCH  = 32,
  parameter int W    = 8,
  localparam int SW  = $clog2(NSTR),
  localparam int CW  = $clog2(NCH),
  localparam int AW  = SW + CW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSTR-1:0]          rx_in,
  input  logic                     tick,
  input  logic                     last_bit,
  input  logic [CW-1:0]            chan,
  input  logic                     wbank,
  input  logic                     rd_bank,
  input  logic [NSTR-1:0][AW-1:0]  rd_addr,
  output logic [NSTR-1:0][W-1:0]   rd_byte,
  input  logic [AW:0]              host_addr,
  output logic [W-1:0]             host_data
);

  logic [NSTR-1:0][W-2:0] sh_q;
  logic [NSTR-1:0][W-1:0] in_byte;
  logic                   wr_evt;
  logic [W-1:0]           bank_mem [2][NSTR*NCH];

  assign wr_evt = tick && last_bit;

  for (genvar s = 0; s < NSTR; s++) begin : g_in
    assign in_byte[s] = {sh_q[s], rx_in[s]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (tick) begin
      for (int s = 0; s < NSTR; s++) sh_q[s] <= in_byte[s][W-2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_evt) begin
      for (int s = 0; s < NSTR; s++) bank_mem[wbank][{SW'(s), chan}] <= in_byte[s];
    end
  end

  for (genvar o = 0; o < NSTR; o++) begin : g_rd
    logic [SW-1:0] src_strm;
    logic          hit;
    assign src_strm   = rd_addr[o][AW-1:CW];
    assign hit        = wr_evt && (rd_bank == wbank) && (rd_addr[o][CW-1:0] == chan);
    assign rd_byte[o] = hit ? in_byte[src_strm] : bank_mem[rd_bank][rd_addr[o]];
  end

  assign host_data = bank_mem[host_addr[AW]][host_addr[AW-1:0]];

  a_r7_byte_stored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (bank_mem[$past(wbank)][{SW'(0), $past(chan)}] == $past(in_byte[0])));

endmodule

// File: rtl/tsx_conn_mem.sv
module tsx_conn_mem #(
  parameter int NSTR = 8,
  parameter int NCH  = 32,
  localparam int SW  = $clog2(NSTR),
  localparam int CW  = $clog2(NCH),
  localparam int AW  = SW + CW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [AW-1:0]           wr_src,
  input  tsx_pkg::cm_hi_t         wr_hi,
  input  logic [CW-1:0]           chan_next,
  output logic [NSTR-1:0][AW-1:0] nxt_src,
  output logic [NSTR-1:0]         nxt_oe,
  input  logic [AW-1:0]           cc_addr,
  output logic                    cc_bit,
  input  logic [AW-1:0]           host_addr,
  output logic [AW-1:0]           host_src,
  output tsx_pkg::cm_hi_t         host_hi
);

  logic [AW-1:0]   lo_q [NSTR*NCH];
  tsx_pkg::cm_hi_t hi_q [NSTR*NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTR*NCH; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
    end else if (wr_en) begin
      lo_q[wr_addr] <= wr_src;
      hi_q[wr_addr] <= wr_hi;
    end
  end

  for (genvar o = 0; o < NSTR; o++) begin : g_nxt
    assign nxt_src[o] = lo_q[{SW'(o), chan_next}];
    assign nxt_oe[o]  = hi_q[{SW'(o), chan_next}].oe;
  end

  assign cc_bit   = hi_q[cc_addr].cc;
  assign host_src = lo_q[host_addr];
  assign host_hi  = hi_q[host_addr];

  a_r12_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (lo_q[$past(wr_addr)] == $past(wr_src) && hi_q[$past(wr_addr)] == $past(wr_hi)));

endmodule

// File: rtl/tsx_tx_out.sv
module tsx_tx_out #(
  parameter int NSTR = 8,
  parameter int W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   load,
  input  logic [NSTR-1:0][W-1:0] ld_byte,
  input  logic [NSTR-1:0]        ld_oe,
  input  logic                   ode,
  output logic [NSTR-1:0]        tx_out,
  output logic [NSTR-1:0]        tx_oe
);

  logic [NSTR-1:0][W-1:0] sh_q;
  logic [NSTR-1:0]        oe_q;
  logic [NSTR-1:0]        ld_msb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0;
      oe_q <= '0;
    end else if (tick) begin
      if (load) begin
        sh_q <= ld_byte;
        oe_q <= ld_oe;
      end else begin
        for (int s = 0; s < NSTR; s++) sh_q[s] <= {sh_q[s][W-2:0], 1'b0};
      end
    end
  end

  for (genvar s = 0; s < NSTR; s++) begin : g_bit
    assign tx_out[s] = sh_q[s][W-1];
    assign ld_msb[s] = ld_byte[s][W-1];
  end

  assign tx_oe = ode ? oe_q : '0;

  a_r9_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && load) |=> $stable(oe_q));

  a_r5_msb_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && load) |=> (tx_out == $past(ld_msb)));

endmodule

// File: rtl/tsx_switch_core.sv
module tsx_switch_core #(
  parameter int NSTR = 8,
  parameter int NCH  = 32,
  parameter int W    = 8,
  parameter int CPB  = 2,
  localparam int SW  = $clog2(NSTR),
  localparam int CW  = $clog2(NCH),
  localparam int BW  = $clog2(W),
  localparam int AW  = SW + CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fp_n,
  input  logic            ode,
  input  logic [NSTR-1:0] rx_in,
  output logic [NSTR-1:0] tx_out,
  output logic [NSTR-1:0] tx_oe,
  output logic            cc_out,
  input  logic            cm_wr_en,
  input  logic [AW-1:0]   cm_wr_addr,
  input  logic [AW-1:0]   cm_wr_src,
  input  logic            cm_wr_oe,
  input  logic            cm_wr_cc,
  input  logic [AW-1:0]   cm_rd_addr,
  output logic [AW-1:0]   cm_rd_src,
  output logic            cm_rd_oe,
  output logic            cm_rd_cc,
  input  logic [AW:0]     dm_rd_addr,
  output logic [W-1:0]    dm_rd_data
);

  logic                    tick, last_bit, frame_start, wbank;
  logic [CW-1:0]           chan, chan_next;
  logic [BW-1:0]           bpos;
  logic                    load, rd_bank;
  logic [NSTR-1:0][AW-1:0] nxt_src;
  logic [NSTR-1:0]         nxt_oe;
  logic [NSTR-1:0][W-1:0]  rd_byte;
  logic [AW-1:0]           cc_addr;
  tsx_pkg::cm_hi_t         wr_hi, host_hi;

  assign load    = tick && (last_bit || frame_start);
  assign rd_bank = frame_start ? wbank : ~wbank;
  assign cc_addr = {SW'(bpos), chan};
  assign wr_hi   = '{oe: cm_wr_oe, cc: cm_wr_cc};
  assign cm_rd_oe = host_hi.oe;
  assign cm_rd_cc = host_hi.cc;

  tsx_timing #(.CPB(CPB), .NCH(NCH), .W(W)) u_timing (
    .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .tick(tick), .last_bit(last_bit),
    .frame_start(frame_start), .chan(chan), .chan_next(chan_next), .bpos(bpos), .wbank(wbank)
  );

  tsx_rx_store #(.NSTR(NSTR), .NCH(NCH), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick(tick), .last_bit(last_bit),
    .chan(chan), .wbank(wbank), .rd_bank(rd_bank), .rd_addr(nxt_src), .rd_byte(rd_byte),
    .host_addr(dm_rd_addr), .host_data(dm_rd_data)
  );

  tsx_conn_mem #(.NSTR(NSTR), .NCH(NCH)) u_cmem (
    .clk(clk), .rst_n(rst_n), .wr_en(cm_wr_en), .wr_addr(cm_wr_addr), .wr_src(cm_wr_src),
    .wr_hi(wr_hi), .chan_next(chan_next), .nxt_src(nxt_src), .nxt_oe(nxt_oe),
    .cc_addr(cc_addr), .cc_bit(cc_out), .host_addr(cm_rd_addr), .host_src(cm_rd_src),
    .host_hi(host_hi)
  );

  tsx_tx_out #(.NSTR(NSTR), .W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .ld_byte(rd_byte), .ld_oe(nxt_oe),
    .ode(ode), .tx_out(tx_out), .tx_oe(tx_oe)
  );

endmodule

// File: tb/sim_tsx_switch_core.sv
`timescale 1ns/1ps
module sim_tsx_switch_core;

  logic       clk = 1'b0, rst_n = 1'b0, fp_n = 1'b1, ode = 1'b1;
  logic [7:0] rx_in = '0;
  logic [7:0] tx_out, tx_oe;
  logic       cc_out;
  logic       cm_wr_en = 1'b0, cm_wr_oe = 1'b0, cm_wr_cc = 1'b0;
  logic [7:0] cm_wr_addr = '0, cm_wr_src = '0, cm_rd_addr = '0;
  logic [7:0] cm_rd_src;
  logic       cm_rd_oe, cm_rd_cc;
  logic [8:0] dm_rd_addr = '0;
  logic [7:0] dm_rd_data;

  int n_run = 0, n_fail = 0;
  logic [7:0] m_src [256];
  bit         m_oe  [256];
  bit         m_cc  [256];
  logic [7:0] got   [2][256];
  logic [7:0] rxb   [256];

  always #2.5 clk = ~clk;

  tsx_switch_core u0 (
    .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .ode(ode), .rx_in(rx_in), .tx_out(tx_out),
    .tx_oe(tx_oe), .cc_out(cc_out), .cm_wr_en(cm_wr_en), .cm_wr_addr(cm_wr_addr),
    .cm_wr_src(cm_wr_src), .cm_wr_oe(cm_wr_oe), .cm_wr_cc(cm_wr_cc), .cm_rd_addr(cm_rd_addr),
    .cm_rd_src(cm_rd_src), .cm_rd_oe(cm_rd_oe), .cm_rd_cc(cm_rd_cc),
    .dm_rd_addr(dm_rd_addr), .dm_rd_data(dm_rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_oe(input int c, input bit ode_v);
    logic [7:0] v;
    for (int s = 0; s < 8; s++) v[s] = ode_v & m_oe[s*32 + c];
    return v;
  endfunction

  function automatic logic [7:0] exp_data(input int f, input int c, input int p);
    logic [7:0] v;
    for (int s = 0; s < 8; s++) v[s] = got[(f - 1) & 1][m_src[s*32 + c]][7 - p];
    return v;
  endfunction

  task automatic run_frame(input int f, input int cut, input bit pulse_end, input bit ode_v);
    for (int i = 0; i < 256; i++) rxb[i] = 8'($urandom);
    for (int b = 0; b < 256; b++) begin
      int c;
      int p;
      logic [7:0] eo;
      string tag;
      c = b / 8;
      p = b % 8;
      for (int s = 0; s < 8; s++) rx_in[s] = rxb[s*32 + c][7 - p];
      fp_n = !((b == cut) || (b == 255 && pulse_end));
      ode  = ode_v;
      if (f == 0) begin
        cm_wr_en = 1'b1; cm_wr_addr = 8'(b); cm_wr_src = m_src[b];
        cm_wr_oe = m_oe[b]; cm_wr_cc = m_cc[b];
      end
      if (f == 1) cm_rd_addr = 8'(b);
      @(posedge clk);
      @(negedge clk);
      cm_wr_en = 1'b0;
      if (f == 1) begin
        chk("R12 src", cm_rd_src, m_src[b]);
        chk("R12 flags", {cm_rd_oe, cm_rd_cc}, {m_oe[b], m_cc[b]});
      end
      if (f >= 2) begin
        eo = exp_oe(c, ode_v);
        chk(ode_v ? "R9" : "R10", tx_oe, eo);
        if (c == 0)               tag = "R8";
        else if (f == 3)          tag = "R4 R6";
        else if (f == 6)          tag = "R3 R7";
        else if (f == 8)          tag = "R7 R6";
        else                      tag = "R2 R5 R6";
        chk(tag, tx_out & eo, exp_data(f, c, p) & eo);
        chk("R11", cc_out, m_cc[p*32 + c]);
      end
      @(posedge clk);
      @(negedge clk);
      if (p == 7) for (int s = 0; s < 8; s++) got[f & 1][s*32 + c] = rxb[s*32 + c];
      if (b == cut) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_ed01));
    for (int k = 0; k < 256; k++) begin
      int s;
      int c;
      s = k / 32;
      c = k % 32;
      m_src[k] = 8'($urandom);
      if (c == 0) m_src[k] = {3'($urandom), (s < 4) ? 5'd31 : 5'd12};
      m_oe[k] = (($urandom % 4) != 0);
      m_cc[k] = 1'($urandom);
    end

    repeat (4) @(negedge clk);
    cm_rd_addr = 8'h25;
    #1;
    chk("R1 oe", tx_oe, 8'h00);
    chk("R1 cc", cc_out, 1'b0);
    chk("R1 cm", {cm_rd_src, cm_rd_oe, cm_rd_cc}, 10'h0);

    @(negedge clk);
    rst_n = 1'b1;
    run_frame(0, -1, 1'b1, 1'b1);
    run_frame(1, -1, 1'b1, 1'b1);
    run_frame(2, -1, 1'b0, 1'b1);   // free-running wrap (R4)
    run_frame(3, -1, 1'b1, 1'b1);
    run_frame(4, -1, 1'b1, 1'b0);   // global drive off (R10)
    run_frame(5, 103, 1'b0, 1'b1);  // pulse on the last bit of channel 12 (R3, R8)
    run_frame(6, -1, 1'b1, 1'b1);
    run_frame(7, 50, 1'b0, 1'b1);   // pulse mid-channel 6 (R7)
    run_frame(8, -1, 1'b1, 1'b1);
    run_frame(9, 50, 1'b0, 1'b1);

    for (int s = 0; s < 8; s++) begin
      int chs [3];
      chs = '{5, 6, 20};
      for (int j = 0; j < 3; j++) begin
        dm_rd_addr = {1'b1, 3'(s), 5'(chs[j])};
        #0.05;
        chk("R7 dm", dm_rd_data, got[1][s*32 + chs[j]]);
      end
    end

    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    cm_rd_addr = 8'h41;
    #1;
    chk("R1 oe mid", tx_oe, 8'h00);
    chk("R1 cm mid", {cm_rd_src, cm_rd_oe, cm_rd_cc}, 10'h0);
    chk("R1 cc mid", cc_out, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule